// File: doc/BRIEF.md
# AC-link codec reset controller

This block sits on the codec side of an AC'97-style serial link and decides which of three resets is in effect. A cold reset, driven by the active-low `rst_n` pin, clears the whole core, registers included. A warm reset brings a halted link back without touching register contents. A register reset clears only the register index ranges that hold defaults. The block runs on a free-running reference clock. It samples the incoming bit clock and SYNC through synchronizers, so it can tell whether the bit clock is toggling, and it sees register writes as strobes in the reference domain.

The outputs control the rest of the codec. `core_clr` clears the core. `reg_clr`, together with `reg_clr_sel`, clears selected register ranges. `bclk_osc_en` enables the bit-clock oscillator. `sdin_oe` lets serial data back onto the link. In primary mode the block owns the oscillator. A halt request stops it, and a SYNC pulse of sufficient length, ending while the clock is stopped, restarts it after a guard delay. In secondary mode the oscillator stays off. The link comes back when the incoming bit clock resumes, and serial data returns on the first frame after the clock is stable.

Top module: `ac_link_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_clr` is 1, `bclk_osc_en` is 0, `sdin_oe` is 0 and `reg_clr` is 0. `core_clr` falls within 3 reference cycles after `rst_n` rises.
- R2: After a cold reset is released with `secondary`=0, `bclk_osc_en` becomes 1 within 4 reference cycles. With `secondary`=1 it stays 0.
- R3: A `halt_req` pulse clears `bclk_osc_en` on the next cycle. Once the bit clock has shown no edge for `STOP_TIMEOUT` reference cycles, it counts as stopped and `sdin_oe` drops to 0.
- R4: In primary mode, a warm reset restarts the oscillator (`bclk_osc_en` returns to 1). A warm reset is SYNC held high for at least `MIN_PULSE_CYC` reference cycles while the bit clock is stopped, then driven low. Register ranges are not cleared (`reg_clr` stays 0).
- R5: After the SYNC fall that ends a warm reset, `bclk_osc_en` stays 0 for at least `RESTART_DLY` reference cycles (default 17, which covers two nominal bit-clock periods).
- R6: No warm reset results from a SYNC high pulse shorter than `MIN_PULSE_CYC`. None results from a pulse during which the bit clock was running for part of the time, even if the pulse as a whole is longer than `MIN_PULSE_CYC`. In both cases `bclk_osc_en` stays 0.
- R7: `sdin_oe` rises only after the bit clock has produced `STABLE_EDGES` consecutive edges and then a SYNC rising edge (frame start) has been seen. Stability alone keeps it at 0.
- R8: In secondary mode, when the bit clock resumes after being stopped, the link is restored: `sdin_oe` returns after stability plus the next frame start, and `bclk_osc_en` remains 0.
- R9: A write strobe to index `RST_IDX` (default 00h) with `codec_ready`=1 while the bit clock is running produces a one-cycle `reg_clr` pulse on the cycle after the write. With it, `reg_clr_sel` is 2'b11: bit 0 selects the range 00h-38h, and bit 1 selects the range 5Ah-7Ah. A write to any other index, with `codec_ready`=0, or with the bit clock stopped, leaves `reg_clr` at 0 and `reg_clr_sel` at 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low cold reset pin |
| secondary | input | 1 | 1 = secondary codec (bit clock supplied from outside) |
| bit_clk | input | 1 | Bit clock as seen on the link, asynchronous |
| sync | input | 1 | Link SYNC, asynchronous |
| halt_req | input | 1 | One-cycle request to stop the bit-clock oscillator |
| codec_ready | input | 1 | Codec-ready flag |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | IDX_W | Register write index |
| core_clr | output | 1 | Whole-core clear, held during cold reset |
| bclk_osc_en | output | 1 | Bit-clock oscillator enable |
| sdin_oe | output | 1 | Serial data output enable |
| reg_clr | output | 1 | One-cycle register range clear |
| reg_clr_sel | output | 2 | Range selects: bit 0 = 00h-38h, bit 1 = 5Ah-7Ah |

## Verification
The bench is built so that a wrong internal state reaches the ports within a few dozen reference cycles. A bit-clock monitor stuck at "running" shows up as `sdin_oe` staying high after the clock halts. A high-time counter that keeps counting while the clock runs shows up as `bclk_osc_en` rising after a pulse that should be rejected. A restart delay loaded with the wrong count moves the `bclk_osc_en` rising edge outside the measured window after the SYNC fall. A frame-wait state that is skipped raises `sdin_oe` before any frame start. A missing ready or link gate on register writes produces a stray `reg_clr` pulse on the next cycle.

// File: rtl/ac_rst_pkg.sv
package ac_rst_pkg;
   typedef enum logic [1:0] {
      SD_OFF        = 2'd0,
      SD_WAIT_FRAME = 2'd1,
      SD_ON         = 2'd2
   } sdin_st_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/bclk_monitor.sv
module bclk_monitor #(
   parameter int unsigned STOP_TIMEOUT = 40,
   parameter int unsigned STABLE_EDGES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   output logic stopped,
   output logic stable,
   output logic resume
);
   localparam int unsigned GW = ac_rst_pkg::cnt_width(STOP_TIMEOUT);
   localparam int unsigned EW = ac_rst_pkg::cnt_width(STABLE_EDGES);

   if (STOP_TIMEOUT < 3) begin : g_chk_to
      $error("STOP_TIMEOUT must be at least 3");
   end
   if (STABLE_EDGES < 1) begin : g_chk_se
      $error("STABLE_EDGES must be at least 1");
   end

   logic          bs1, bs2, bs3;
   logic          edge_seen;
   logic [GW-1:0] gap_cnt;
   logic [EW-1:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bs1 <= 1'b0;
         bs2 <= 1'b0;
         bs3 <= 1'b0;
      end else begin
         bs1 <= bclk_in;
         bs2 <= bs1;
         bs3 <= bs2;
      end
   end

   assign edge_seen = bs2 ^ bs3;
   assign stopped   = (gap_cnt == GW'(STOP_TIMEOUT));
   assign resume    = edge_seen && stopped;
   assign stable    = (edge_cnt == EW'(STABLE_EDGES)) && !stopped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= GW'(STOP_TIMEOUT);
      end else if (edge_seen) begin
         gap_cnt <= '0;
      end else if (!stopped) begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
      end else if (stopped && !edge_seen) begin
         edge_cnt <= '0;
      end else if (edge_seen && (edge_cnt != EW'(STABLE_EDGES))) begin
         edge_cnt <= edge_cnt + 1'b1;
      end
   end

   AST_EDGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_seen |=> !stopped) else $error("edge left monitor stopped"); // R3
endmodule

// File: rtl/warm_detect.sv
module warm_detect #(
   parameter int unsigned MIN_PULSE_CYC = 100,
   parameter int unsigned RESTART_DLY   = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_s,
   input  logic stopped,
   input  logic secondary,
   output logic restart,
   output logic busy
);
   localparam int unsigned HW = ac_rst_pkg::cnt_width(MIN_PULSE_CYC);
   localparam int unsigned DW = ac_rst_pkg::cnt_width(RESTART_DLY);

   if (MIN_PULSE_CYC < 1) begin : g_chk_mp
      $error("MIN_PULSE_CYC must be at least 1");
   end
   if (RESTART_DLY < 2) begin : g_chk_rd
      $error("RESTART_DLY must be at least 2");
   end

   logic          sync_q;
   logic          sync_fall;
   logic          arm;
   logic [HW-1:0] hi_cnt;
   logic [DW-1:0] dly_cnt;

   assign sync_fall = sync_q && !sync_s;
   assign arm       = sync_fall && stopped && !secondary &&
                      (hi_cnt == HW'(MIN_PULSE_CYC));
   assign busy      = (dly_cnt != '0);
   assign restart   = (dly_cnt == DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         hi_cnt <= '0;
      end else begin
         sync_q <= sync_s;
         if (!(sync_s && stopped)) begin
            hi_cnt <= '0;
         end else if (hi_cnt != HW'(MIN_PULSE_CYC)) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_cnt <= '0;
      end else if (arm) begin
         dly_cnt <= DW'(RESTART_DLY);
      end else if (busy) begin
         dly_cnt <= dly_cnt - 1'b1;
      end
   end

   AST_WARM_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stopped)) else $error("warm armed while clock ran"); // R6
endmodule

// File: rtl/reg_reset_gate.sv
module reg_reset_gate #(
   parameter int unsigned IDX_W      = 7,
   parameter int unsigned RST_IDX    = 0,
   parameter bit          CLR_VENDOR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             ready,
   input  logic             link_up,
   output logic             clr,
   output logic [1:0]       sel
);
   if (RST_IDX >= (1 << IDX_W)) begin : g_chk_idx
      $error("RST_IDX does not fit in IDX_W bits");
   end

   logic [1:0] sel_mask;
   logic       hit;

   if (CLR_VENDOR) begin : g_both
      assign sel_mask = 2'b11;
   end else begin : g_std
      assign sel_mask = 2'b01;
   end

   assign hit = wr_en && (wr_idx == IDX_W'(RST_IDX)) && ready && link_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr <= 1'b0;
         sel <= 2'b00;
      end else begin
         clr <= hit;
         sel <= hit ? sel_mask : 2'b00;
      end
   end

   AST_CLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> $past(ready && link_up)) else $error("register clear not gated"); // R9
endmodule

// File: rtl/ac_link_reset_ctrl.sv
module ac_link_reset_ctrl
   import ac_rst_pkg::*;
#(
   parameter int unsigned IDX_W         = 7,
   parameter int unsigned RST_IDX       = 0,
   parameter bit          CLR_VENDOR    = 1'b1,
   parameter int unsigned MIN_PULSE_CYC = 100,
   parameter int unsigned STOP_TIMEOUT  = 40,
   parameter int unsigned STABLE_EDGES  = 8,
   parameter int unsigned RESTART_DLY   = 17
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             secondary,
   input  logic             bit_clk,
   input  logic             sync,
   input  logic             halt_req,
   input  logic             codec_ready,
   input  logic             reg_wr_en,
   input  logic [IDX_W-1:0] reg_wr_idx,
   output logic             core_clr,
   output logic             bclk_osc_en,
   output logic             sdin_oe,
   output logic             reg_clr,
   output logic [1:0]       reg_clr_sel
);
   logic     rs1, rs2;
   logic     irst_n;
   logic     ss1, ss2, sync_d;
   logic     sync_rise;
   logic     clk_stopped, clk_stable, clk_resume;
   logic     warm_restart, warm_busy;
   logic     started;
   sdin_st_e sd_st;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         rs1 <= 1'b0;
         rs2 <= 1'b0;
      end else begin
         rs1 <= 1'b1;
         rs2 <= rs1;
      end
   end

   assign irst_n   = rs2;
   assign core_clr = !rs2;

   always_ff @(posedge ref_clk or negedge irst_n) begin
      if (!irst_n) begin
         ss1    <= 1'b0;
         ss2    <= 1'b0;
         sync_d <= 1'b0;
      end else begin
         ss1    <= sync;
         ss2    <= ss1;
         sync_d <= ss2;
      end
   end

   assign sync_rise = ss2 && !sync_d;

   bclk_monitor #(
      .STOP_TIMEOUT (STOP_TIMEOUT),
      .STABLE_EDGES (STABLE_EDGES)
   ) u_mon (
      .clk     (ref_clk),
      .rst_n   (irst_n),
      .bclk_in (bit_clk),
      .stopped (clk_stopped),
      .stable  (clk_stable),
      .resume  (clk_resume)
   );

   warm_detect #(
      .MIN_PULSE_CYC (MIN_PULSE_CYC),
      .RESTART_DLY   (RESTART_DLY)
   ) u_warm (
      .clk       (ref_clk),
      .rst_n     (irst_n),
      .sync_s    (ss2),
      .stopped   (clk_stopped),
      .secondary (secondary),
      .restart   (warm_restart),
      .busy      (warm_busy)
   );

   reg_reset_gate #(
      .IDX_W      (IDX_W),
      .RST_IDX    (RST_IDX),
      .CLR_VENDOR (CLR_VENDOR)
   ) u_gate (
      .clk     (ref_clk),
      .rst_n   (irst_n),
      .wr_en   (reg_wr_en),
      .wr_idx  (reg_wr_idx),
      .ready   (codec_ready),
      .link_up (!clk_stopped),
      .clr     (reg_clr),
      .sel     (reg_clr_sel)
   );

   always_ff @(posedge ref_clk or negedge irst_n) begin
      if (!irst_n) begin
         bclk_osc_en <= 1'b0;
         started     <= 1'b0;
      end else begin
         started <= 1'b1;
         if (secondary || halt_req) begin
            bclk_osc_en <= 1'b0;
         end else if (!started || warm_restart) begin
            bclk_osc_en <= 1'b1;
         end
      end
   end

   always_ff @(posedge ref_clk or negedge irst_n) begin
      if (!irst_n) begin
         sd_st <= SD_OFF;
      end else if (clk_stopped) begin
         sd_st <= SD_OFF;
      end else begin
         unique case (sd_st)
            SD_OFF:        if (clk_stable) sd_st <= SD_WAIT_FRAME;
            SD_WAIT_FRAME: if (sync_rise)  sd_st <= SD_ON;
            SD_ON:         sd_st <= SD_ON;
            default:       sd_st <= SD_OFF;
         endcase
      end
   end

   assign sdin_oe = (sd_st == SD_ON);

   always_ff @(posedge ref_clk) begin
      if (!rst_n) begin
         AST_COLD_HOLDS: assert (core_clr) else $error("core clear dropped in reset"); // R1
      end
   end

   AST_OSC_WAITS: assert property (@(posedge ref_clk) disable iff (!irst_n)
      warm_busy |-> !bclk_osc_en) else $error("oscillator on during guard"); // R5

   AST_SDIN_DROPS: assert property (@(posedge ref_clk) disable iff (!irst_n)
      clk_stopped |=> !sdin_oe) else $error("serial data on with clock stopped"); // R3

   AST_SEC_NO_OSC: assert property (@(posedge ref_clk) disable iff (!irst_n)
      secondary |=> !bclk_osc_en) else $error("oscillator on in secondary mode"); // R8

   AST_FRAME_FIRST: assert property (@(posedge ref_clk) disable iff (!irst_n)
      $rose(sdin_oe) |-> $past(sync_rise)) else $error("data enabled without frame"); // R7
endmodule

// File: tb/tb_ac_link_reset_ctrl.sv
`timescale 1ns/1ps
module tb_ac_link_reset_ctrl;
   localparam int IDX_W = 7;
   localparam int MINP  = 100;
   localparam int STOPT = 40;
   localparam int STABE = 8;
   localparam int RDLY  = 17;

   logic             ref_clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             secondary = 1'b0;
   logic             bit_clk = 1'b0;
   logic             sync = 1'b0;
   logic             halt_req = 1'b0;
   logic             codec_ready = 1'b0;
   logic             reg_wr_en = 1'b0;
   logic [IDX_W-1:0] reg_wr_idx = '0;
   logic             core_clr, bclk_osc_en, sdin_oe, reg_clr;
   logic [1:0]       reg_clr_sel;

   logic             sec_on = 1'b0;
   logic [1:0]       bc_cnt = '0;
   int               checks = 0;
   int               errors = 0;
   bit               done = 1'b0;

   always #5 ref_clk = ~ref_clk;

   ac_link_reset_ctrl #(
      .IDX_W (IDX_W), .RST_IDX (0), .CLR_VENDOR (1'b1),
      .MIN_PULSE_CYC (MINP), .STOP_TIMEOUT (STOPT),
      .STABLE_EDGES (STABE), .RESTART_DLY (RDLY)
   ) dut (
      .ref_clk (ref_clk), .rst_n (rst_n), .secondary (secondary),
      .bit_clk (bit_clk), .sync (sync), .halt_req (halt_req),
      .codec_ready (codec_ready), .reg_wr_en (reg_wr_en),
      .reg_wr_idx (reg_wr_idx), .core_clr (core_clr),
      .bclk_osc_en (bclk_osc_en), .sdin_oe (sdin_oe),
      .reg_clr (reg_clr), .reg_clr_sel (reg_clr_sel)
   );

   // bit clock model: primary runs from the oscillator enable, secondary from sec_on
   always @(posedge ref_clk) begin
      if (secondary ? sec_on : bclk_osc_en) begin
         bc_cnt <= bc_cnt + 1'b1;
         if (bc_cnt == 2'd3) bit_clk <= ~bit_clk;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge ref_clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   function automatic bit exp_clr(input logic [IDX_W-1:0] idx, input bit rdy, input bit link);
      return (idx == '0) && rdy && link;
   endfunction

   task automatic frame();
      sync = 1'b1; cyc(16); sync = 1'b0; cyc(8);
   endtask

   task automatic write_chk(input logic [IDX_W-1:0] idx, input bit rdy, input bit link);
      bit e;
      e = exp_clr(idx, rdy, link);
      codec_ready = rdy; reg_wr_idx = idx; reg_wr_en = 1'b1;
      cyc(1);
      reg_wr_en = 1'b0;
      check(reg_clr == e, "R9 clr", int'(reg_clr), int'(e));
      check(reg_clr_sel == (e ? 2'b11 : 2'b00), "R9 sel", int'(reg_clr_sel), e ? 3 : 0);
      cyc(1);
      check(reg_clr == 1'b0, "R9 single cycle", int'(reg_clr), 0);
   endtask

   task automatic cold(input bit sec);
      rst_n = 1'b0; secondary = sec; cyc(20);
      check(core_clr == 1'b1, "R1 core_clr", int'(core_clr), 1);
      check(bclk_osc_en == 1'b0 && sdin_oe == 1'b0 && reg_clr == 1'b0,
            "R1 outputs idle", int'({bclk_osc_en, sdin_oe, reg_clr}), 0);
      rst_n = 1'b1; cyc(3);
      check(core_clr == 1'b0, "R1 release", int'(core_clr), 0);
      cyc(1);
      check(bclk_osc_en == !sec, "R2 osc after cold", int'(bclk_osc_en), int'(!sec));
   endtask

   initial begin
      int unused_seed;
      int n;
      unused_seed = $urandom(32'h5EED);
      cyc(2);

      // primary cold bring-up
      cold(1'b0);
      cyc(STABE * 8 + 30);
      check(sdin_oe == 1'b0, "R7 no frame yet", int'(sdin_oe), 0);
      frame();
      check(sdin_oe == 1'b1, "R7 on after frame", int'(sdin_oe), 1);

      // register reset directed cases
      write_chk(7'h00, 1'b1, 1'b1);
      write_chk(7'h02, 1'b1, 1'b1);
      write_chk(7'h00, 1'b0, 1'b1);
      write_chk(7'h5A, 1'b1, 1'b1);

      // random register writes on a running link
      for (int i = 0; i < 60; i++) begin
         logic [IDX_W-1:0] idx;
         idx = ($urandom % 3 == 0) ? '0 : IDX_W'($urandom);
         write_chk(idx, bit'($urandom % 2), 1'b1);
      end

      // halt; pulse that straddles the running clock is ignored
      halt_req = 1'b1; cyc(1); halt_req = 1'b0;
      check(bclk_osc_en == 1'b0, "R3 halt clears osc", int'(bclk_osc_en), 1'b0);
      cyc(1);
      sync = 1'b1; cyc(MINP + 20); sync = 1'b0; cyc(RDLY + 20);
      check(bclk_osc_en == 1'b0, "R6 pulse while running", int'(bclk_osc_en), 0);
      check(sdin_oe == 1'b0, "R3 sdin drops when stopped", int'(sdin_oe), 0);
      write_chk(7'h00, 1'b1, 1'b0);

      // short pulse while stopped
      sync = 1'b1; cyc(MINP - 20); sync = 1'b0; cyc(RDLY + 20);
      check(bclk_osc_en == 1'b0, "R6 short pulse", int'(bclk_osc_en), 0);

      // valid warm reset; measure restart delay
      sync = 1'b1; cyc(MINP + 10); sync = 1'b0;
      n = 0;
      while (bclk_osc_en == 1'b0 && n < 200) begin
         cyc(1); n++;
         check(reg_clr == 1'b0, "R4 no register clear", int'(reg_clr), 0);
      end
      check(bclk_osc_en == 1'b1, "R4 warm restart", int'(bclk_osc_en), 1);
      check(n >= RDLY && n <= RDLY + 6, "R5 restart delay", n, RDLY);
      cyc(STABE * 8 + 30);
      check(sdin_oe == 1'b0, "R7 warm wait frame", int'(sdin_oe), 0);
      frame();
      check(sdin_oe == 1'b1, "R7 warm data back", int'(sdin_oe), 1);

      // secondary mode
      cold(1'b1);
      sec_on = 1'b1; cyc(STABE * 8 + 30);
      frame();
      check(sdin_oe == 1'b1, "R8 secondary link up", int'(sdin_oe), 1);
      sec_on = 1'b0; cyc(STOPT + 20);
      check(sdin_oe == 1'b0, "R3 secondary stop", int'(sdin_oe), 0);
      write_chk(7'h00, 1'b1, 1'b0);
      sec_on = 1'b1; cyc(20);
      check(sdin_oe == 1'b0, "R8 not before stable", int'(sdin_oe), 0);
      cyc(STABE * 8 + 20);
      frame();
      check(sdin_oe == 1'b1, "R8 resumed", int'(sdin_oe), 1);
      check(bclk_osc_en == 1'b0, "R8 osc stays off", int'(bclk_osc_en), 0);
      write_chk(7'h00, 1'b1, 1'b1);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule